// File: doc/BRIEF.md
# Serial/Parallel Control Word Latch

This block holds a six-bit control word and drives it onto six switch-driver bits. Each bit comes out twice: once as itself and once inverted. The word can arrive in two ways, chosen by a mode pin:
- **Serial:** a three-wire interface (data, shift clock, latch enable) shifts bits in, most significant first.
- **Parallel:** six input pins feed the word directly.

An internal input register collects the word. A separate output latch only takes the register's value while latch enable is high. While latch enable is low, the outputs stay frozen whatever happens on the other pins. In parallel mode this gives two styles of use:
- **Transparent:** latch enable held high, so the outputs track the pins.
- **Latched:** the pins are set up first and then captured with one latch-enable pulse.

All external pins are sampled by a fast system clock. The shift clock, shift data and latch enable each pass through a two-flop synchroniser, and the shift clock then goes through a rising-edge detector. The system clock must run at least four times the serial bit rate. After reset the outputs stay cleared for `PUP_DELAY` system cycles. The block then loads its start-up word, chosen by the latch-enable level at that moment:
- **Latch enable low:** the word comes from a four-entry table indexed by two select pins.
- **Latch enable high:** the word comes from the parallel pins.

Top module: `ctrl_word_latch`

## Requirements
- R1: With mode_ser high and latch enable low, each rising edge of sclk shifts sdata into the input register at bit 0 and moves the older bits up, so after six edges the first bit sent is bit 5 (MSB-first).
- R2: While latch enable is high, after the start-up word has loaded, the output latch takes the input register's value.
- R3: While latch enable is high, sclk edges do not shift the input register.
- R4: With mode_ser low, the input register follows par_in every cycle, and sdata/sclk have no effect.
- R5: After start-up, the outputs keep their value for as long as latch enable stays low, in either mode.
- R6: With mode_ser low and latch enable held high, the outputs follow par_in within a few system cycles.
- R7: With mode_ser low, a single latch-enable pulse captures the par_in value present at the pulse, and that value is held after the pulse.
- R8: If latch enable is low at start-up, the start-up word is chosen by pup_sel = {sel1, sel0}: 00 gives 000000, 01 gives 000001, 10 gives 100000, 11 gives 111111.
- R9: If latch enable is high at start-up, the start-up word is par_in.
- R10: From reset until PUP_DELAY cycles after reset release, drv_q is all zeros.
- R11: drv_qn is always the bitwise inverse of drv_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ser | input | 1 | 1 selects the serial interface, 0 selects parallel |
| sdata | input | 1 | Serial data bit |
| sclk | input | 1 | Serial shift clock, rising-edge active |
| latch_en | input | 1 | Latch enable; high transfers the register to the outputs |
| par_in | input | 6 | Parallel control word, bit 5 is the MSB |
| pup_sel | input | 2 | Start-up word select {sel1, sel0} |
| drv_q | output | 6 | True driver outputs |
| drv_qn | output | 6 | Complementary driver outputs |

## Verification
The bench sends two serial words and checks that each lands MSB-first. A reversed shift direction would show up mirrored, and an off-by-one would show up shifted by a bit. It toggles sclk while latch enable is high and while in parallel mode. A design that failed to mask the clock in either case would show a changed word on the outputs. It changes the inputs while latch enable is low; a design that leaks there would show new values where the old word should hold. Each start-up path is taken through a fresh reset: all four table codes, and the parallel-pin word. This catches swapped table entries, an inverted latch-enable selection, and outputs that appear before the delay has run out.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  localparam int unsigned WORD_W = 6;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_PUP  = 1 << SEL_W;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_PUP-1:0][WORD_W-1:0] pup_tab_t;
endpackage

// File: rtl/cwl_sync.sv
module cwl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cwl_pwrup.sv
module cwl_pwrup
  import cwl_pkg::*;
#(
  parameter int unsigned PUP_DELAY = 16,
  parameter pup_tab_t    PUP_TAB   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le_s,
  input  word_t            par_in,
  input  logic [SEL_W-1:0] pup_sel,
  output logic             load,
  output logic             done,
  output word_t            init_val
);
  localparam int unsigned CNT_W = $clog2(PUP_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PUP_DELAY - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end

  assign load     = !done && (cnt == LAST);
  assign init_val = le_s ? par_in : PUP_TAB[pup_sel];

  p_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !load);
endmodule

// File: rtl/cwl_shift.sv
module cwl_shift
  import cwl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_ser,
  input  logic  le_s,
  input  logic  sclk_rise,
  input  logic  sdata_s,
  input  word_t par_in,
  input  logic  load,
  input  word_t init_val,
  output word_t shreg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          shreg <= '0;
    else if (load)                       shreg <= init_val;
    else if (!mode_ser)                  shreg <= par_in;
    else if (!le_s && sclk_rise)         shreg <= {shreg[WORD_W-2:0], sdata_s};
  end

  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ser && !le_s && sclk_rise && !load) |=>
      shreg == {$past(shreg[WORD_W-2:0]), $past(sdata_s)});

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ser && le_s && !load) |=> $stable(shreg));

  p_par_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ser && !load) |=> shreg == $past(par_in));
endmodule

// File: rtl/ctrl_word_latch.sv
module ctrl_word_latch
  import cwl_pkg::*;
#(
  parameter int unsigned PUP_DELAY = 16,
  parameter pup_tab_t PUP_TAB = {{WORD_W{1'b1}},
                                 {1'b1, {(WORD_W-1){1'b0}}},
                                 {{(WORD_W-1){1'b0}}, 1'b1},
                                 {WORD_W{1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ser,
  input  logic              sdata,
  input  logic              sclk,
  input  logic              latch_en,
  input  logic [WORD_W-1:0] par_in,
  input  logic [SEL_W-1:0]  pup_sel,
  output logic [WORD_W-1:0] drv_q,
  output logic [WORD_W-1:0] drv_qn
);
  logic [2:0] raw, syn;
  logic  sdata_s, sclk_s, le_s, sclk_d, sclk_rise;
  logic  load, done;
  word_t init_val, shreg, out_r;

  assign raw = {sdata, sclk, latch_en};

  cwl_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );
  assign {sdata_s, sclk_s, le_s} = syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end
  assign sclk_rise = sclk_s && !sclk_d;

  cwl_pwrup #(.PUP_DELAY(PUP_DELAY), .PUP_TAB(PUP_TAB)) u_pwrup (
    .clk(clk), .rst_n(rst_n), .le_s(le_s), .par_in(par_in),
    .pup_sel(pup_sel), .load(load), .done(done), .init_val(init_val)
  );

  cwl_shift u_shift (
    .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .le_s(le_s),
    .sclk_rise(sclk_rise), .sdata_s(sdata_s), .par_in(par_in),
    .load(load), .init_val(init_val), .shreg(shreg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            out_r <= '0;
    else if (load)         out_r <= init_val;
    else if (done && le_s) out_r <= shreg;
  end

  assign drv_q  = out_r;
  assign drv_qn = ~out_r;

  p_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && le_s) |=> drv_q == $past(shreg));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !le_s) |=> $stable(drv_q));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> drv_q == '0);

  p_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> drv_q == $past(init_val));
endmodule

// File: tb/test_ctrl_word_latch.sv
module test_ctrl_word_latch;
  localparam int DLY = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_ser = 1'b0, sdata = 1'b0, sclk = 1'b0, latch_en = 1'b0;
  logic [5:0] par_in = '0;
  logic [1:0] pup_sel = '0;
  logic [5:0] drv_q, drv_qn;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ctrl_word_latch #(.PUP_DELAY(DLY)) i_ctrl_word_latch (
    .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .sdata(sdata),
    .sclk(sclk), .latch_en(latch_en), .par_in(par_in), .pup_sel(pup_sel),
    .drv_q(drv_q), .drv_qn(drv_qn)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] exp);
    n_chk++;
    if (drv_q !== exp || drv_qn !== ~exp) begin
      n_fail++;
      $display("FAIL %s: drv_q=%b drv_qn=%b expected %b/%b", tag, drv_q, drv_qn, exp, ~exp);
    end
  endtask

  task automatic do_reset(input logic ser, input logic le, input logic [1:0] sel,
                          input logic [5:0] p);
    rst_n = 1'b0; mode_ser = ser; latch_en = le; pup_sel = sel; par_in = p;
    sclk = 1'b0; sdata = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic send_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) begin
      sdata = w[i]; cyc(4);
      sclk = 1'b1;  cyc(4);
      sclk = 1'b0;  cyc(2);
    end
  endtask

  task automatic pulse_le();
    latch_en = 1'b1; cyc(6);
    latch_en = 1'b0; cyc(6);
  endtask

  task automatic t_startup_quiet();
    do_reset(1'b1, 1'b0, 2'b11, 6'h2A);
    cyc(3);
    chk("R10 outputs cleared during start-up delay, R11", 6'h00);
    cyc(DLY - 6);
    chk("R10 outputs still cleared just before delay ends", 6'h00);
    cyc(8);
    chk("R8 code 11 after delay", 6'h3F);
  endtask

  task automatic t_pup_table();
    logic [5:0] exp [4] = '{6'h00, 6'h01, 6'h20, 6'h3F};
    for (int s = 0; s < 4; s++) begin
      do_reset(1'b1, 1'b0, 2'(s), 6'h15);
      cyc(DLY + 6);
      chk($sformatf("R8 start-up code %0d", s), exp[s]);
    end
  endtask

  task automatic t_pup_par();
    do_reset(1'b0, 1'b1, 2'b11, 6'h2D);
    cyc(DLY + 6);
    chk("R9 start-up from par_in", 6'h2D);
    latch_en = 1'b0; cyc(4);
  endtask

  task automatic t_serial();
    do_reset(1'b1, 1'b0, 2'b00, 6'h00);
    cyc(DLY + 6);
    send_word(6'b101101);
    chk("R5 no transfer before latch pulse", 6'h00);
    pulse_le();
    chk("R1 R2 serial word MSB first", 6'b101101);
    send_word(6'b010011);
    chk("R5 output holds while new word shifts", 6'b101101);
    pulse_le();
    chk("R1 R2 second serial word", 6'b010011);
  endtask

  task automatic t_mask();
    latch_en = 1'b1; cyc(6);
    for (int i = 0; i < 3; i++) begin
      sdata = 1'b1; cyc(4); sclk = 1'b1; cyc(4); sclk = 1'b0; cyc(2);
    end
    cyc(4);
    chk("R3 clock masked while latch enable high", 6'b010011);
    latch_en = 1'b0; cyc(6);
    pulse_le();
    chk("R3 register unchanged after masked clocks", 6'b010011);
  endtask

  task automatic t_parallel();
    mode_ser = 1'b0; par_in = 6'h1C; cyc(4);
    chk("R5 parallel change with latch low does not pass", 6'b010011);
    for (int i = 0; i < 3; i++) begin
      sdata = 1'b0; cyc(2); sclk = 1'b1; cyc(3); sclk = 1'b0; cyc(3);
    end
    pulse_le();
    chk("R7 R4 latched parallel capture, serial pins ignored", 6'h1C);
    par_in = 6'h33; cyc(6);
    chk("R7 held after pulse", 6'h1C);
    latch_en = 1'b1; cyc(6);
    chk("R6 transparent follows par_in", 6'h33);
    par_in = 6'h0A; cyc(5);
    chk("R6 transparent follows change", 6'h0A);
    par_in = 6'h35; cyc(5);
    chk("R6 R11 transparent third value", 6'h35);
    latch_en = 1'b0; cyc(6);
    par_in = 6'h00; cyc(6);
    chk("R5 parallel hold after latch drops", 6'h35);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_startup_quiet();
    t_pup_table();
    t_pup_par();
    t_serial();
    t_mask();
    t_parallel();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule